// File: doc/BRIEF.md
# Two-Button Three-Channel Selector

The block lets two momentary buttons choose among three channels. A two-bit state register holds the current channel. Each button's action depends on that state. Button A moves between the third-channel code and the first-channel code. Button B moves between the second-channel code and the first-channel code. A press of either button from the other side of its pair enters that pair. The register is edge-triggered and changes at most once per qualifying press. The state is decoded into three one-hot channel lines.

Both buttons are raw, possibly bouncing, active-high inputs. Each is passed through a synchroniser and then a counter-based debouncer, both clocked by the system clock. A transition is taken only on the press edge of one debounced button while the other button is released. Pressing both at once does nothing. So does pressing one while the other is held. A held button gives one transition and no more.

Top module: `chan_seq`

## Requirements
- R1: After reset the state code {S0,S1} is 11 and `chan_onehot` is 3'b001 (bit 0 = channel 1).
- R2: A debounced press of button A alone takes state 11 to 10 (channel 3, `chan_onehot`=3'b100), takes 01 to 10, and takes 10 to 11 (channel 1, 3'b001).
- R3: A debounced press of button B alone takes state 11 to 01 (channel 2, `chan_onehot`=3'b010), takes 01 to 11, and takes 10 to 01.
- R4: Two presses that land in the same cycle cause no transition. A press of one button while the other is held also causes no transition. The state changes only on a single-button press strobe.
- R5: A button held down for any length of time causes exactly one transition. Releasing it causes none.
- R6: A level on a button input that lasts fewer than `DEB_CYCLES` clock cycles after synchronisation is ignored. A bouncing press that then settles counts as one press.
- R7: `chan_onehot` always has exactly one bit set. The unused code 00 decodes to channel 1 and goes to 11 on the next strobe from either button.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| btn_a | input | 1 | Raw button A, high while pressed |
| btn_b | input | 1 | Raw button B, high while pressed |
| chan_onehot | output | 3 | Selected channel, one-hot: bit 0 = channel 1, bit 1 = channel 2, bit 2 = channel 3 |

## Verification
The assertions assume that the raw buttons, once synchronised and debounced, never yield strobes from both buttons in the same cycle. They also assume that each strobe is a single-cycle pulse. The properties check these two assumptions about the internal strobes, and then relate each strobe to the state it finds and the state it leaves. The stimulus holds each press and each release for far longer than the debounce window. Bursts meant to be filtered are kept shorter than that window. As a result, every intended transition is separated in time and can be checked against the transition table one at a time.

// File: rtl/chan_seq.sv
module chan_seq #(
  parameter int SYNC_STAGES = 2,
  parameter int DEB_CYCLES  = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       btn_a,
  input  logic       btn_b,
  output logic [2:0] chan_onehot
);
  localparam int CNT_W = $clog2(DEB_CYCLES + 1);

  logic [1:0] raw;
  logic [1:0] pressed;
  logic [1:0] rise;
  logic       step_a, step_b;
  logic [1:0] state_q, state_d;

  assign raw = {btn_b, btn_a};

  for (genvar g = 0; g < 2; g++) begin : g_btn
    logic [SYNC_STAGES-1:0] sync_q;
    logic [CNT_W-1:0]       cnt_q;
    logic                   stab_q, prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sync_q <= '0;
        cnt_q  <= '0;
        stab_q <= 1'b0;
        prev_q <= 1'b0;
      end else begin
        sync_q <= {sync_q[SYNC_STAGES-2:0], raw[g]};
        prev_q <= stab_q;
        if (sync_q[SYNC_STAGES-1] == stab_q) begin
          cnt_q <= '0;
        end else if (cnt_q == CNT_W'(DEB_CYCLES - 1)) begin
          stab_q <= sync_q[SYNC_STAGES-1];
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end

    assign pressed[g] = stab_q;
    assign rise[g]    = stab_q & ~prev_q;
  end

  assign step_a = rise[0] & ~pressed[1];
  assign step_b = rise[1] & ~pressed[0];

  always_comb begin
    state_d = state_q;
    if (step_a) begin
      case (state_q)
        2'b11:   state_d = 2'b10;
        2'b01:   state_d = 2'b10;
        default: state_d = 2'b11;
      endcase
    end else if (step_b) begin
      case (state_q)
        2'b11:   state_d = 2'b01;
        2'b10:   state_d = 2'b01;
        default: state_d = 2'b11;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= 2'b11;
    else        state_q <= state_d;
  end

  always_comb begin
    case (state_q)
      2'b01:   chan_onehot = 3'b010;
      2'b10:   chan_onehot = 3'b100;
      default: chan_onehot = 3'b001;
    endcase
  end
endmodule

module chan_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] chan,
  input logic       step_a,
  input logic       step_b,
  input logic [1:0] state
);
  AST_ONE_CHANNEL: assert property (@(posedge clk) disable iff (!rst_n) $countones(chan) == 1); // R7
  AST_STROBES_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(step_a && step_b)); // R4
  AST_HOLD_STATE: assert property (@(posedge clk) disable iff (!rst_n) (!step_a && !step_b) |=> $stable(state)); // R4
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) (step_a || step_b) |=> !(step_a || step_b)); // R5
  AST_A_FROM_11: assert property (@(posedge clk) disable iff (!rst_n) (step_a && state == 2'b11) |=> state == 2'b10); // R2
  AST_A_FROM_01: assert property (@(posedge clk) disable iff (!rst_n) (step_a && state == 2'b01) |=> state == 2'b10); // R2
  AST_A_FROM_10: assert property (@(posedge clk) disable iff (!rst_n) (step_a && state == 2'b10) |=> state == 2'b11); // R2
  AST_B_FROM_11: assert property (@(posedge clk) disable iff (!rst_n) (step_b && state == 2'b11) |=> state == 2'b01); // R3
  AST_B_FROM_01: assert property (@(posedge clk) disable iff (!rst_n) (step_b && state == 2'b01) |=> state == 2'b11); // R3
  AST_B_FROM_10: assert property (@(posedge clk) disable iff (!rst_n) (step_b && state == 2'b10) |=> state == 2'b01); // R3
  AST_ZERO_RECOVER: assert property (@(posedge clk) disable iff (!rst_n) ((step_a || step_b) && state == 2'b00) |=> state == 2'b11); // R7
endmodule

bind chan_seq chan_seq_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .chan   (chan_onehot),
  .step_a (step_a),
  .step_b (step_b),
  .state  (state_q)
);

// File: tb/chan_seq_bench.sv
module chan_seq_bench;
  localparam int DEB  = 8;
  localparam int HOLD = 40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       btn_a = 1'b0;
  logic       btn_b = 1'b0;
  logic [2:0] chan_onehot;

  int total = 0;
  int bad   = 0;
  logic [1:0] model = 2'b11;
  logic [2:0] exp_q[$];
  logic [2:0] last_chan;
  bit done = 0;

  always #5 clk = ~clk;

  chan_seq #(.SYNC_STAGES(2), .DEB_CYCLES(DEB)) u_chan_seq (
    .clk(clk), .rst_n(rst_n), .btn_a(btn_a), .btn_b(btn_b), .chan_onehot(chan_onehot)
  );

  function automatic logic [2:0] dec(input logic [1:0] s);
    case (s)
      2'b01:   return 3'b010;
      2'b10:   return 3'b100;
      default: return 3'b001;
    endcase
  endfunction

  function automatic logic [1:0] nxt(input logic [1:0] s, input bit is_a);
    if (is_a) return (s == 2'b11 || s == 2'b01) ? 2'b10 : 2'b11;
    return (s == 2'b11 || s == 2'b10) ? 2'b01 : 2'b11;
  endfunction

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: chan_onehot=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic press(input bit is_a, input string req);
    model = nxt(model, is_a);
    exp_q.push_back(dec(model));
    if (is_a) btn_a = 1'b1; else btn_b = 1'b1;
    idle(HOLD);
    if (is_a) btn_a = 1'b0; else btn_b = 1'b0;
    idle(HOLD);
    @(negedge clk);
    check(req, chan_onehot, dec(model));
  endtask

  // monitor: pops one expected value per observed output change
  initial begin
    @(posedge rst_n);
    @(negedge clk);
    last_chan = chan_onehot;
    forever begin
      @(negedge clk);
      if (chan_onehot !== last_chan) begin
        total++;
        if ($countones(chan_onehot) != 1) begin
          bad++;
          $display("FAIL R7: chan_onehot=%b expected one bit set", chan_onehot);
        end
        if (exp_q.size() == 0) begin
          bad++;
          $display("FAIL R4/R5: unexpected change chan_onehot=%b expected=%b", chan_onehot, last_chan);
        end else begin
          logic [2:0] e;
          e = exp_q.pop_front();
          if (chan_onehot !== e) begin
            bad++;
            $display("FAIL R2/R3: chan_onehot=%b expected=%b", chan_onehot, e);
          end
        end
        last_chan = chan_onehot;
      end
    end
  end

  initial begin
    fork
      begin
        idle(100000);
        if (!done) begin
          bad++;
          total++;
          $display("FAIL watchdog: run=hung expected=finished");
          $display("test done: total=%0d bad=%0d", total, bad);
          $finish;
        end
      end
    join_none

    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset", chan_onehot, 3'b001);
    idle(HOLD);
    check("R1 idle after reset", chan_onehot, 3'b001);

    press(1, "R2 A from 11");
    press(1, "R2 A from 10");
    press(0, "R3 B from 11");
    press(0, "R3 B from 01");
    press(0, "R3 B from 11 again");
    press(1, "R2 A from 01");
    press(0, "R3 B from 10");

    // R4: simultaneous press
    btn_a = 1'b1; btn_b = 1'b1;
    idle(HOLD);
    btn_a = 1'b0; btn_b = 1'b0;
    idle(HOLD);
    @(negedge clk);
    check("R4 simultaneous", chan_onehot, dec(model));

    // R4: second button while first held, then release first while second held
    btn_a = 1'b1; idle(2); btn_b = 1'b1;
    model = nxt(model, 1);
    exp_q.push_back(dec(model));
    idle(HOLD);
    @(negedge clk);
    check("R4 A then B held", chan_onehot, dec(model));
    btn_a = 1'b0;
    idle(HOLD);
    @(negedge clk);
    check("R4 release A with B held", chan_onehot, dec(model));
    btn_b = 1'b0;
    idle(HOLD);

    // R4: B held first, A pressed in the middle
    btn_b = 1'b1;
    model = nxt(model, 0);
    exp_q.push_back(dec(model));
    idle(HOLD);
    btn_a = 1'b1; idle(HOLD); btn_a = 1'b0; idle(HOLD);
    btn_b = 1'b0;
    idle(HOLD);
    @(negedge clk);
    check("R4 A during B hold", chan_onehot, dec(model));

    // R5: long hold
    btn_a = 1'b1;
    model = nxt(model, 1);
    exp_q.push_back(dec(model));
    idle(20 * HOLD);
    @(negedge clk);
    check("R5 long hold", chan_onehot, dec(model));
    btn_a = 1'b0;
    idle(HOLD);
    @(negedge clk);
    check("R5 release", chan_onehot, dec(model));

    // R6: short glitches
    for (int i = 0; i < 4; i++) begin
      btn_b = 1'b1; idle(DEB - 4); btn_b = 1'b0; idle(HOLD);
    end
    @(negedge clk);
    check("R6 glitch B", chan_onehot, dec(model));
    btn_a = 1'b1; idle(3); btn_a = 1'b0; idle(HOLD);
    @(negedge clk);
    check("R6 glitch A", chan_onehot, dec(model));

    // R6: bouncing press settles to one transition
    model = nxt(model, 0);
    exp_q.push_back(dec(model));
    for (int i = 0; i < 5; i++) begin
      btn_b = 1'b1; idle(2); btn_b = 1'b0; idle(2);
    end
    btn_b = 1'b1; idle(HOLD);
    for (int i = 0; i < 3; i++) begin
      btn_b = 1'b0; idle(2); btn_b = 1'b1; idle(2);
    end
    btn_b = 1'b0; idle(HOLD);
    @(negedge clk);
    check("R6 bounce", chan_onehot, dec(model));

    total++;
    if (exp_q.size() != 0) begin
      bad++;
      $display("FAIL R2/R3: pending transitions=%0d expected=0", exp_q.size());
    end
    @(negedge clk);
    check("R7 final one-hot", 3'(($countones(chan_onehot) == 1) ? 3'b001 : 3'b000), 3'b001);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule